// File: doc/BRIEF.md
# Power-On Reset Marker Generator

This block handles start-up signalling on a shared open-drain data line. While the supply indicator reports a voltage below the reset threshold, the block stays in its hold state and asks the configuration registers to take their default values. Once the supply has stayed above the threshold for a programmable number of clock cycles, the block leaves the hold state. It then sends a square wave with a 50% duty cycle onto the line. This marker runs at a frequency below any legal data rate, so the attached controller can tell that a reset has just happened.

The marker continues until the controller holds the line low for long enough. The line is open-drain with an external pull-up. During the low half of the marker the block pulls the line low itself. During the high half it releases the line. The block therefore looks for a foreign low only in the released half. The sensed pin level passes through a synchronizer. For this reason, the first few samples of each released half are ignored, because they still show the block's own low drive. After a cancel, the block releases the line for good and clears its marker-active status until the next supply reset.

The block has four states. ST_HOLD applies the defaults and times the reset hold. ST_MARK_HI is the released half of the marker and the only state where cancel samples are taken. ST_MARK_LO is the driven-low half. ST_DONE is the state after a cancel. The transitions are as follows:
- hold expiry: ST_HOLD to ST_MARK_HI.
- half expiry: ST_MARK_HI to ST_MARK_LO, and back from ST_MARK_LO to ST_MARK_HI.
- cancel: ST_MARK_HI to ST_DONE.
- supply reset: from any state to ST_HOLD, asynchronously.

Top module: `por_marker_gen`

## Requirements
- R1: While `supply_low` is 1, the block is in ST_HOLD with no clock needed: `load_defaults`=1, `marker_active`=0, `pin_oe`=0.
- R2: After `supply_low` falls, `load_defaults` stays 1 for exactly RST_HOLD rising clock edges and then goes to 0.
- R3: In the cycle `load_defaults` falls, `marker_active` becomes 1 and the marker starts with a released (high) half.
- R4: Each marker half lasts exactly HALF_PERIOD cycles. In the low half `pin_oe`=1 and `pin_out`=0. In the high half `pin_oe`=0 and `pin_out`=1.
- R5: `pin_in` passes through a SYNC_STAGES-flop synchronizer. The first SYNC_STAGES cycles of each high half are ignored for cancel detection.
- R6: The marker is cancelled when CANCEL_LEN qualifying low samples have been counted with no qualifying high sample between them. Cycles in the low half and blanked cycles neither add to the count nor clear it. If an external low begins in the cycle the high half starts, `marker_active` falls SYNC_STAGES+CANCEL_LEN edges after that start.
- R7: A qualifying high sample clears the count. A low pulse shorter than CANCEL_LEN cycles, placed inside one high half, leaves the marker running.
- R8: After a cancel, the block stays in ST_DONE until the next supply reset: `pin_oe`=0, `marker_active`=0, `load_defaults`=0, whatever happens on `pin_in`.
- R9: Asserting `supply_low` in any marker state or in ST_DONE returns the block to ST_HOLD and restarts the whole sequence from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| supply_low | input | 1 | Supply below reset threshold, active high, asynchronous |
| pin_in | input | 1 | Sensed level of the data line |
| pin_oe | output | 1 | Line drive enable (open-drain pull-down) |
| pin_out | output | 1 | Line drive value, 0 while driving |
| load_defaults | output | 1 | Request to load configuration defaults, high during hold |
| marker_active | output | 1 | Reset marker is being sent |

## Verification
On every cycle, the assertions check the following:
- The line is only ever driven low.
- Hold and marker never overlap.
- The marker always starts in its released half.
- ST_DONE is sticky.
- `marker_active` only falls on a cancel hit.
- The cancel counter stays in range.

Only the bench scenarios can show the exact lengths of the hold period and the marker halves, and the precise cancel edge. This includes the case where a pulse straddles the block's own low half and is carried across it, and the sweep of pulse lengths around CANCEL_LEN. The asynchronous restart from the middle of the marker also needs a bench scenario.

// File: rtl/por_marker_pkg.sv
package por_marker_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_MARK_HI = 2'd1,
        ST_MARK_LO = 2'd2,
        ST_DONE    = 2'd3
    } pm_state_e;
endpackage

// File: rtl/pmg_sync.sv
module pmg_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES == 1) begin : g_single
            logic q_r;
            always_ff @(posedge clk or posedge rst) begin
                if (rst) q_r <= RST_VAL;
                else     q_r <= d;
            end
            assign q = q_r;
        end else begin : g_chain
            logic [STAGES-1:0] sh_r;
            always_ff @(posedge clk or posedge rst) begin
                if (rst) sh_r <= {STAGES{RST_VAL}};
                else     sh_r <= {sh_r[STAGES-2:0], d};
            end
            assign q = sh_r[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pmg_timer.sv
module pmg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst)      count <= '0;
        else if (clr) count <= '0;
        else          count <= count + 1'b1;
    end
endmodule

// File: rtl/pmg_cancel_det.sv
module pmg_cancel_det #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic line_lvl,
    output logic hit
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] run_q;

    assign hit = sample_en && !line_lvl && (run_q == LAST);

    // Only qualifying samples move the run; all other cycles hold it.
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            run_q <= '0;
        end else if (sample_en) begin
            if (line_lvl)            run_q <= '0;
            else if (run_q != LAST)  run_q <= run_q + 1'b1;
        end
    end

    assert_run_bound_R6: assert property (@(posedge clk) disable iff (rst)
        run_q <= LAST);

    assert_high_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (sample_en && line_lvl) |=> (run_q == '0));
endmodule

// File: rtl/por_marker_gen.sv
module por_marker_gen
    import por_marker_pkg::*;
#(
    parameter int HALF_PERIOD = 2000,
    parameter int RST_HOLD    = 4096,
    parameter int CANCEL_LEN  = 600,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic supply_low,
    input  logic pin_in,
    output logic pin_oe,
    output logic pin_out,
    output logic load_defaults,
    output logic marker_active
);
    localparam int CMAX = (HALF_PERIOD > RST_HOLD) ? HALF_PERIOD : RST_HOLD;
    localparam int TW   = $clog2(CMAX + 1);
    localparam logic [TW-1:0] HOLD_LAST = TW'(RST_HOLD - 1);
    localparam logic [TW-1:0] HALF_LAST = TW'(HALF_PERIOD - 1);
    localparam logic [TW-1:0] BLANK     = TW'(SYNC_STAGES);

    pm_state_e state_q, state_d;
    logic [TW-1:0] tmr_q;
    logic tmr_clr, line_sync, sample_en, cancel_hit;

    pmg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(supply_low), .d(pin_in), .q(line_sync)
    );

    pmg_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(supply_low), .clr(tmr_clr), .count(tmr_q)
    );

    // Samples taken during blanking still reflect our own low drive.
    assign sample_en = (state_q == ST_MARK_HI) && (tmr_q >= BLANK);

    pmg_cancel_det #(.LEN(CANCEL_LEN)) u_cancel (
        .clk(clk), .rst(supply_low), .sample_en(sample_en),
        .line_lvl(line_sync), .hit(cancel_hit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        tmr_clr = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (tmr_q == HOLD_LAST) begin
                    state_d = ST_MARK_HI;
                    tmr_clr = 1'b1;
                end
            end
            ST_MARK_HI: begin
                if (cancel_hit) begin
                    state_d = ST_DONE;
                    tmr_clr = 1'b1;
                end else if (tmr_q == HALF_LAST) begin
                    state_d = ST_MARK_LO;
                    tmr_clr = 1'b1;
                end
            end
            ST_MARK_LO: begin
                if (tmr_q == HALF_LAST) begin
                    state_d = ST_MARK_HI;
                    tmr_clr = 1'b1;
                end
            end
            ST_DONE: begin
                tmr_clr = 1'b1;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or posedge supply_low) begin
        if (supply_low) state_q <= ST_HOLD;
        else            state_q <= state_d;
    end

    // Outputs
    always_comb begin
        pin_oe        = 1'b0;
        pin_out       = 1'b1;
        load_defaults = 1'b0;
        marker_active = 1'b0;
        unique case (state_q)
            ST_HOLD:    load_defaults = 1'b1;
            ST_MARK_HI: marker_active = 1'b1;
            ST_MARK_LO: begin
                marker_active = 1'b1;
                pin_oe        = 1'b1;
                pin_out       = 1'b0;
            end
            ST_DONE:    ;
        endcase
    end

    assert_drive_low_only_R4: assert property (@(posedge clk) disable iff (supply_low)
        pin_oe |-> (!pin_out && marker_active));

    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (supply_low)
        !(load_defaults && marker_active));

    assert_start_high_R3: assert property (@(posedge clk) disable iff (supply_low)
        $fell(load_defaults) |-> (marker_active && !pin_oe));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (supply_low)
        (state_q == ST_DONE) |=> (state_q == ST_DONE && !pin_oe && !marker_active));

    assert_cancel_cause_R6: assert property (@(posedge clk) disable iff (supply_low)
        $fell(marker_active) |-> $past(cancel_hit));

    assert_low_half_hold_R4: assert property (@(posedge clk) disable iff (supply_low)
        (state_q == ST_MARK_LO && tmr_q != HALF_LAST) |=> (state_q == ST_MARK_LO));
endmodule

// File: tb/por_marker_gen_tb_top.sv
module por_marker_gen_tb_top;
    localparam int HALF = 12;
    localparam int RSTH = 5;
    localparam int CAN  = 6;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic supply_low = 1'b1;
    logic ext_low = 1'b0;
    logic pin_in, pin_oe, pin_out, load_defaults, marker_active;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    // Open-drain line with pull-up: low if the block or the controller pulls.
    assign pin_in = !(pin_oe && !pin_out) && !ext_low;

    por_marker_gen #(.HALF_PERIOD(HALF), .RST_HOLD(RSTH), .CANCEL_LEN(CAN),
                     .SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .supply_low(supply_low), .pin_in(pin_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .load_defaults(load_defaults), .marker_active(marker_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_hold_outputs(input string req);
        chk(load_defaults && !marker_active && !pin_oe, req,
            {load_defaults, marker_active, pin_oe}, 3'b100);
    endtask

    task automatic release_hold(output int n);
        @(negedge clk);
        supply_low = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (load_defaults && n < 200);
    endtask

    task automatic run_len(input bit lvl, output int n);
        n = 0;
        while (pin_oe == lvl && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_hi_start();
        int g = 0;
        while (!pin_oe && g < 1000) begin @(negedge clk); g++; end
        while (pin_oe && g < 1000) begin @(negedge clk); g++; end
    endtask

    // Called at the first sample of a high half (k = 0); returns the first k
    // at which marker_active reads 0, or -1 if it never falls.
    task automatic pulse(input int start, input int len, output int fall_k);
        fall_k = -1;
        if (start == 0) ext_low = 1'b1;
        for (int k = 1; k <= 50; k++) begin
            @(negedge clk);
            if (k == start) ext_low = 1'b1;
            if (k == start + len) ext_low = 1'b0;
            if (fall_k < 0 && !marker_active) fall_k = k;
        end
        ext_low = 1'b0;
    endtask

    task automatic restart_and_check(input string req);
        int n;
        @(negedge clk);
        supply_low = 1'b1;
        #1;
        check_hold_outputs(req);
        repeat (3) @(negedge clk);
        release_hold(n);
        chk(n == RSTH, req, n, RSTH);
    endtask

    initial begin
        int n, fk;
        bit ok;
        repeat (4) @(negedge clk);
        check_hold_outputs("R1 reset state");

        release_hold(n);
        chk(n == RSTH, "R2 hold length", n, RSTH);
        chk(marker_active && !pin_oe, "R3 marker starts released", {marker_active, pin_oe}, 2'b10);
        run_len(1'b0, n);
        chk(n == HALF, "R3 first high half length", n, HALF);
        for (int p = 0; p < 3; p++) begin
            chk(pin_oe && !pin_out, "R4 low half drives 0", {pin_oe, pin_out}, 2'b10);
            run_len(1'b1, n);
            chk(n == HALF, "R4 low half length", n, HALF);
            chk(!pin_oe && pin_out && marker_active, "R4 high half released",
                {pin_oe, pin_out, marker_active}, 3'b011);
            run_len(1'b0, n);
            chk(n == HALF, "R4 high half length", n, HALF);
        end

        // Pulse straddling the block's own low half: 2 samples, hold, 4 more after blanking.
        wait_hi_start();
        pulse(8, 60, fk);
        chk(fk == 2*HALF + SYNC + CAN - 2, "R5 R6 count carried across low half",
            fk, 2*HALF + SYNC + CAN - 2);

        ok = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            ext_low = k[1];
            if (pin_oe || marker_active || load_defaults) ok = 1'b0;
        end
        ext_low = 1'b0;
        chk(ok, "R8 idle after cancel", ok, 1);

        restart_and_check("R9 restart from done");

        // Sweep pulse lengths from the start of a high half.
        for (int len = 1; len <= HALF - SYNC; len++) begin
            int exp_k;
            wait_hi_start();
            pulse(0, len, fk);
            exp_k = (len >= CAN) ? SYNC + CAN : -1;
            if (len >= CAN) chk(fk == exp_k, "R6 cancel edge", fk, exp_k);
            else            chk(fk == exp_k, "R7 short pulse ignored", fk, exp_k);
            restart_and_check("R9 restart in sweep");
        end

        // Reset in the middle of a driven-low half.
        while (!pin_oe) @(negedge clk);
        repeat (3) @(negedge clk);
        restart_and_check("R9 restart mid marker");
        run_len(1'b0, n);
        chk(n == HALF, "R9 marker restarts high", n, HALF);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule